// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block decides, every cycle, how a five-stage integer pipeline (fetch, decode, execute, memory, writeback) must react to data and control hazards. It looks at the register fields, valid bits and load/branch flags of the instructions held in each stage. From these it drives the hold enables for fetch and decode, a bubble insert into execute, squash signals for the younger stages, the operand bypass selects for the instruction in execute, and a request to reload the program counter. It keeps no state of its own, so every output follows from the stage contents of the same cycle.

A mode pin picks one of two hazard policies. With `modeFwd` low there is no bypass network. A consumer waits in decode until its producer has reached writeback, because the register file hands a value written in a cycle to a read in that same cycle. Every instruction fetched behind a branch is squashed until the branch resolves in the memory stage. With `modeFwd` high, results are bypassed from the EX/MEM and MEM/WB pipeline registers, so only a load followed by a dependent instruction costs a stall. Branches are predicted not taken, and a taken branch squashes the three instructions behind it.

Top module: `hazard_unit`

## Requirements
- R1: When no stage holds a valid instruction, all hold, bubble, squash and redirect outputs are 0 and both bypass selects are 2'b00, in either mode.
- R2: With modeFwd=0, if a valid decode instruction has a nonzero source equal to the destination of a valid, register-writing instruction in EX or in MEM, then stallIf, stallId and bubbleEx are all 1.
- R3: With modeFwd=0, a producer that has reached WB causes no stall, because the register file passes a same-cycle write through to the read.
- R4: With modeFwd=0, fwdA and fwdB stay 2'b00 whatever registers match.
- R5: With modeFwd=0 and no stall, a valid branch in ID, EX or MEM raises flushIf. A valid branch in MEM raises pcRedirect whether or not it is taken. If a stall is active, flushIf stays 0 so that the held instruction is not lost.
- R6: With modeFwd=1, a match against an ALU producer in EX causes no stall. A match against a load in EX raises stallIf, stallId and bubbleEx.
- R7: With modeFwd=1, the bypass select for each EX source reads 2'b10 when the valid writing instruction in MEM targets it and 2'b01 when only the valid writing instruction in WB does. Otherwise it reads 2'b00. When both match, MEM wins.
- R8: Register 0 is never bypassed and never causes a stall.
- R9: With modeFwd=1, a valid taken branch in MEM raises pcRedirect, flushIf, flushId and flushEx and overrides any load-use stall. A not-taken branch changes nothing.
- R10: A producer that is invalid or does not write a register is ignored for stalls and bypasses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used only by the checks) |
| rstN | input | 1 | Active-low reset |
| modeFwd | input | 1 | 0: interlock and flush; 1: bypass and predict not taken |
| idValid | input | 1 | Decode stage holds an instruction |
| idRs1 | input | REG_W | Decode source 1 (0 = unused) |
| idRs2 | input | REG_W | Decode source 2 (0 = unused) |
| idIsBranch | input | 1 | Decode instruction is a branch |
| exValid | input | 1 | Execute stage holds an instruction |
| exRs1 | input | REG_W | Execute source 1 |
| exRs2 | input | REG_W | Execute source 2 |
| exRd | input | REG_W | Execute destination |
| exWrites | input | 1 | Execute instruction writes a register |
| exIsLoad | input | 1 | Execute instruction is a load |
| exIsBranch | input | 1 | Execute instruction is a branch |
| memValid | input | 1 | Memory stage holds an instruction |
| memRd | input | REG_W | Memory-stage destination |
| memWrites | input | 1 | Memory-stage instruction writes a register |
| memIsBranch | input | 1 | Memory-stage instruction is a branch |
| memTaken | input | 1 | Branch outcome in the memory stage |
| wbValid | input | 1 | Writeback stage holds an instruction |
| wbRd | input | REG_W | Writeback destination |
| wbWrites | input | 1 | Writeback instruction writes a register |
| stallIf | output | 1 | Hold the program counter |
| stallId | output | 1 | Hold the IF/ID register |
| bubbleEx | output | 1 | Load a bubble into ID/EX |
| flushIf | output | 1 | Turn the fetched instruction into a bubble |
| flushId | output | 1 | Turn the decode instruction into a bubble |
| flushEx | output | 1 | Turn the execute instruction into a bubble |
| fwdA | output | 2 | Bypass select for EX source 1 |
| fwdB | output | 2 | Bypass select for EX source 2 |
| pcRedirect | output | 1 | Load the PC from the resolved branch |

## Verification
The block is combinational, so a wrong comparison or wrong policy gating shows up at the ports in the same cycle the stage contents appear. It appears either as a hold that is missing or spurious, or as a bypass select that points at the wrong pipeline register. Because the two modes share the match logic, each pattern is applied under both settings of modeFwd, and the difference in outputs shows whether the policy gating is right. Squash and redirect errors show as a flush output or redirect that is missing, or that fires while a stall is holding decode.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwdSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic fwdEn;
  } ctlStrobe_t;

  // datapath -> control match results
  typedef struct packed {
    logic hitEx;
    logic hitMem;
    logic loadUse;
  } depHit_t;
endpackage

// File: rtl/hazard_dp.sv
module hazard_dp
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic             idValid,
  input  logic [REG_W-1:0] idRs1,
  input  logic [REG_W-1:0] idRs2,
  input  logic             exValid,
  input  logic [REG_W-1:0] exRs1,
  input  logic [REG_W-1:0] exRs2,
  input  logic [REG_W-1:0] exRd,
  input  logic             exWrites,
  input  logic             exIsLoad,
  input  logic             memValid,
  input  logic [REG_W-1:0] memRd,
  input  logic             memWrites,
  input  logic             wbValid,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbWrites,
  output depHit_t          hits,
  output logic [1:0]       fwdA,
  output logic [1:0]       fwdB
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  function automatic logic srcHit(input logic [REG_W-1:0] src,
                                  input logic [REG_W-1:0] dst,
                                  input logic vld, input logic wr);
    return vld && wr && (src != ZERO_REG) && (src == dst);
  endfunction

  logic [1:0] idHitEx, idHitMem;
  logic [REG_W-1:0] exSrc [2];
  logic [1:0] fwdSel [2];

  assign exSrc[0] = exRs1;
  assign exSrc[1] = exRs2;

  always_comb begin
    idHitEx[0]  = srcHit(idRs1, exRd,  exValid,  exWrites);
    idHitEx[1]  = srcHit(idRs2, exRd,  exValid,  exWrites);
    idHitMem[0] = srcHit(idRs1, memRd, memValid, memWrites);
    idHitMem[1] = srcHit(idRs2, memRd, memValid, memWrites);
    hits.hitEx   = idValid && (|idHitEx);
    hits.hitMem  = idValid && (|idHitMem);
    hits.loadUse = idValid && (|idHitEx) && exIsLoad;
  end

  for (genvar s = 0; s < 2; s++) begin : g_fwd
    always_comb begin
      fwdSel[s] = FWD_RF;
      if (strobe.fwdEn && exValid) begin
        if (srcHit(exSrc[s], memRd, memValid, memWrites))
          fwdSel[s] = FWD_MEM;
        else if (srcHit(exSrc[s], wbRd, wbValid, wbWrites))
          fwdSel[s] = FWD_WB;
      end
    end
  end

  assign fwdA = fwdSel[0];
  assign fwdB = fwdSel[1];

  assert_no_bypass_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fwdEn |-> (fwdA == FWD_RF && fwdB == FWD_RF));
  assert_zero_not_fwd_R8: assert property (@(posedge clk) disable iff (!rstN)
    (exRs1 == ZERO_REG) |-> (fwdA == FWD_RF));
  assert_mem_priority_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fwdEn && exValid && memValid && memWrites && memRd == exRs2 && exRs2 != ZERO_REG)
      |-> (fwdB == FWD_MEM));
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hazard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeFwd,
  input  depHit_t    hits,
  input  logic       idValid,
  input  logic       idIsBranch,
  input  logic       exValid,
  input  logic       exIsBranch,
  input  logic       exIsLoad,
  input  logic       memValid,
  input  logic       memIsBranch,
  input  logic       memTaken,
  output ctlStrobe_t strobe,
  output logic       stallIf,
  output logic       stallId,
  output logic       bubbleEx,
  output logic       flushIf,
  output logic       flushId,
  output logic       flushEx,
  output logic       pcRedirect
);
  logic brPending, brResolve, brTaken, hold;

  assign brPending = (idValid && idIsBranch) || (exValid && exIsBranch) || (memValid && memIsBranch);
  assign brResolve = memValid && memIsBranch;
  assign brTaken   = brResolve && memTaken;

  always_comb begin
    strobe.fwdEn = modeFwd;
    if (modeFwd) begin
      hold       = hits.loadUse && !brTaken;
      flushIf    = brTaken;
      flushId    = brTaken;
      flushEx    = brTaken;
      pcRedirect = brTaken;
    end else begin
      hold       = hits.hitEx || hits.hitMem;
      flushIf    = brPending && !hold;
      flushId    = 1'b0;
      flushEx    = 1'b0;
      pcRedirect = brResolve;
    end
  end

  assign stallIf  = hold;
  assign stallId  = hold;
  assign bubbleEx = hold;

  assert_fwd_stall_is_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeFwd && stallId) |-> (exValid && exIsLoad));
  assert_taken_squash_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeFwd && memValid && memIsBranch && memTaken)
      |-> (flushIf && flushId && flushEx && pcRedirect && !stallId));
  assert_hold_wins_flush_R5: assert property (@(posedge clk) disable iff (!rstN)
    !modeFwd |-> !(stallId && flushIf));
  assert_redirect_src_R5: assert property (@(posedge clk) disable iff (!rstN)
    pcRedirect |-> (memValid && memIsBranch));
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeFwd,
  input  logic             idValid,
  input  logic [REG_W-1:0] idRs1,
  input  logic [REG_W-1:0] idRs2,
  input  logic             idIsBranch,
  input  logic             exValid,
  input  logic [REG_W-1:0] exRs1,
  input  logic [REG_W-1:0] exRs2,
  input  logic [REG_W-1:0] exRd,
  input  logic             exWrites,
  input  logic             exIsLoad,
  input  logic             exIsBranch,
  input  logic             memValid,
  input  logic [REG_W-1:0] memRd,
  input  logic             memWrites,
  input  logic             memIsBranch,
  input  logic             memTaken,
  input  logic             wbValid,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbWrites,
  output logic             stallIf,
  output logic             stallId,
  output logic             bubbleEx,
  output logic             flushIf,
  output logic             flushId,
  output logic             flushEx,
  output logic [1:0]       fwdA,
  output logic [1:0]       fwdB,
  output logic             pcRedirect
);
  ctlStrobe_t strobe;
  depHit_t    hits;

  hazard_dp #(.REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .idValid(idValid), .idRs1(idRs1), .idRs2(idRs2),
    .exValid(exValid), .exRs1(exRs1), .exRs2(exRs2), .exRd(exRd),
    .exWrites(exWrites), .exIsLoad(exIsLoad),
    .memValid(memValid), .memRd(memRd), .memWrites(memWrites),
    .wbValid(wbValid), .wbRd(wbRd), .wbWrites(wbWrites),
    .hits(hits), .fwdA(fwdA), .fwdB(fwdB)
  );

  hazard_ctl u_ctl (
    .clk(clk), .rstN(rstN), .modeFwd(modeFwd), .hits(hits),
    .idValid(idValid), .idIsBranch(idIsBranch),
    .exValid(exValid), .exIsBranch(exIsBranch), .exIsLoad(exIsLoad),
    .memValid(memValid), .memIsBranch(memIsBranch), .memTaken(memTaken),
    .strobe(strobe), .stallIf(stallIf), .stallId(stallId), .bubbleEx(bubbleEx),
    .flushIf(flushIf), .flushId(flushId), .flushEx(flushEx), .pcRedirect(pcRedirect)
  );

  assert_stall_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    stallId |-> (stallIf && bubbleEx && idValid));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!idValid && !exValid && !memValid && !wbValid)
      |-> !(stallIf || flushIf || flushId || flushEx || pcRedirect || (|fwdA) || (|fwdB)));
endmodule

// File: tb/hazard_unit_bench.sv
module hazard_unit_bench;
  localparam int REG_W = 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic modeFwd;
  logic idValid, idIsBranch, exValid, exWrites, exIsLoad, exIsBranch;
  logic memValid, memWrites, memIsBranch, memTaken, wbValid, wbWrites;
  logic [REG_W-1:0] idRs1, idRs2, exRs1, exRs2, exRd, memRd, wbRd;
  logic stallIf, stallId, bubbleEx, flushIf, flushId, flushEx, pcRedirect;
  logic [1:0] fwdA, fwdB;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hazard_unit #(.REG_W(REG_W)) u_hazard_unit (
    .clk(clk), .rstN(rstN), .modeFwd(modeFwd),
    .idValid(idValid), .idRs1(idRs1), .idRs2(idRs2), .idIsBranch(idIsBranch),
    .exValid(exValid), .exRs1(exRs1), .exRs2(exRs2), .exRd(exRd),
    .exWrites(exWrites), .exIsLoad(exIsLoad), .exIsBranch(exIsBranch),
    .memValid(memValid), .memRd(memRd), .memWrites(memWrites),
    .memIsBranch(memIsBranch), .memTaken(memTaken),
    .wbValid(wbValid), .wbRd(wbRd), .wbWrites(wbWrites),
    .stallIf(stallIf), .stallId(stallId), .bubbleEx(bubbleEx),
    .flushIf(flushIf), .flushId(flushId), .flushEx(flushEx),
    .fwdA(fwdA), .fwdB(fwdB), .pcRedirect(pcRedirect)
  );

  // packed view: {stall3, flushIf, flushId, flushEx, redirect, fwdA, fwdB}
  function automatic logic [10:0] exp(input bit st, input bit fi, input bit fd, input bit fe,
                                      input bit rd, input logic [1:0] a, input logic [1:0] b);
    return {st, st, st, fi, fd, fe, rd, a, b};
  endfunction

  task automatic idle(input bit m);
    modeFwd = m;
    idValid = 0; idRs1 = 0; idRs2 = 0; idIsBranch = 0;
    exValid = 0; exRs1 = 0; exRs2 = 0; exRd = 0; exWrites = 0; exIsLoad = 0; exIsBranch = 0;
    memValid = 0; memRd = 0; memWrites = 0; memIsBranch = 0; memTaken = 0;
    wbValid = 0; wbRd = 0; wbWrites = 0;
  endtask

  task automatic check(input string req, input logic [10:0] want);
    logic [10:0] got;
    @(negedge clk);
    got = {stallIf, stallId, bubbleEx, flushIf, flushId, flushEx, pcRedirect, fwdA, fwdB};
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, got, want);
    end
  endtask

  task automatic t_idle_R1;
    idle(0); check("R1 idle mode0", exp(0,0,0,0,0,2'b00,2'b00));
    idle(1); check("R1 idle mode1", exp(0,0,0,0,0,2'b00,2'b00));
  endtask

  task automatic t_interlock_R2;
    idle(0); idValid = 1; idRs1 = 3; exValid = 1; exRd = 3; exWrites = 1;
    check("R2 ex producer", exp(1,0,0,0,0,2'b00,2'b00));
    idle(0); idValid = 1; idRs2 = 7; memValid = 1; memRd = 7; memWrites = 1;
    check("R2 mem producer", exp(1,0,0,0,0,2'b00,2'b00));
  endtask

  task automatic t_wb_pass_R3;
    idle(0); idValid = 1; idRs1 = 3; wbValid = 1; wbRd = 3; wbWrites = 1;
    check("R3 wb producer no stall", exp(0,0,0,0,0,2'b00,2'b00));
  endtask

  task automatic t_no_bypass_R4;
    idle(0); exValid = 1; exRs1 = 5; exRs2 = 6;
    memValid = 1; memRd = 5; memWrites = 1; wbValid = 1; wbRd = 6; wbWrites = 1;
    check("R4 selects held at 00", exp(0,0,0,0,0,2'b00,2'b00));
  endtask

  task automatic t_flush_R5;
    idle(0); exValid = 1; exIsBranch = 1;
    check("R5 branch in ex", exp(0,1,0,0,0,2'b00,2'b00));
    idle(0); memValid = 1; memIsBranch = 1; memTaken = 0;
    check("R5 untaken resolve", exp(0,1,0,0,1,2'b00,2'b00));
    idle(0); idValid = 1; idIsBranch = 1; idRs1 = 4; exValid = 1; exRd = 4; exWrites = 1;
    check("R5 stall beats flush", exp(1,0,0,0,0,2'b00,2'b00));
  endtask

  task automatic t_loaduse_R6;
    idle(1); idValid = 1; idRs1 = 3; exValid = 1; exRd = 3; exWrites = 1;
    check("R6 alu producer", exp(0,0,0,0,0,2'b00,2'b00));
    exIsLoad = 1;
    check("R6 load producer", exp(1,0,0,0,0,2'b00,2'b00));
  endtask

  task automatic t_fwd_R7;
    idle(1); exValid = 1; exRs1 = 4; memValid = 1; memRd = 4; memWrites = 1;
    wbValid = 1; wbRd = 4; wbWrites = 1;
    check("R7 mem priority", exp(0,0,0,0,0,2'b10,2'b00));
    idle(1); exValid = 1; exRs2 = 6; wbValid = 1; wbRd = 6; wbWrites = 1;
    check("R7 wb select", exp(0,0,0,0,0,2'b00,2'b01));
  endtask

  task automatic t_zero_R8;
    idle(1); idValid = 1; exValid = 1; exIsLoad = 1; exWrites = 1;
    memValid = 1; memWrites = 1; wbValid = 1; wbWrites = 1;
    check("R8 reg0 mode1", exp(0,0,0,0,0,2'b00,2'b00));
    modeFwd = 0;
    check("R8 reg0 mode0", exp(0,0,0,0,0,2'b00,2'b00));
  endtask

  task automatic t_predict_R9;
    idle(1); idValid = 1; idRs1 = 2; exValid = 1; exRd = 2; exWrites = 1; exIsLoad = 1;
    memValid = 1; memIsBranch = 1; memTaken = 1;
    check("R9 taken squash", exp(0,1,1,1,1,2'b00,2'b00));
    idle(1); memValid = 1; memIsBranch = 1; memTaken = 0;
    check("R9 not taken", exp(0,0,0,0,0,2'b00,2'b00));
  endtask

  task automatic t_ignore_R10;
    idle(0); idValid = 1; idRs1 = 9; exValid = 1; exRd = 9; exWrites = 0;
    check("R10 non-writer", exp(0,0,0,0,0,2'b00,2'b00));
    idle(1); exValid = 1; exRs1 = 9; memValid = 0; memRd = 9; memWrites = 1;
    check("R10 invalid mem", exp(0,0,0,0,0,2'b00,2'b00));
  endtask

  initial begin
    idle(0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_idle_R1;
    t_interlock_R2;
    t_wb_pass_R3;
    t_no_bypass_R4;
    t_flush_R5;
    t_loaduse_R6;
    t_fwd_R7;
    t_zero_R8;
    t_predict_R9;
    t_ignore_R10;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule